// File: doc/BRIEF.md
# SD/eMMC I/O PHY Power-Up Sequencer

This block brings an SD/eMMC I/O PHY out of reset by itself, with no software involved. After a `start` pulse it works through a fixed list of steps on an 8-bit PHY register port. It first sets up the I/O pads and begins impedance calibration. It then polls the calibration status register until calibration reports done, and gives up after a time limit. Finally it turns on the receivers, pull-ups and power-down-bar controls for the command, data, strobe and clock lines, raises the clock buffer selection, and puts the PHY into legacy mode.

Most steps are read-modify-write: the block reads a register, ORs a fixed mask into the returned byte, and writes the result back to the same address. Every register access has its own time limit. If any access does not complete in time, or calibration does not finish in time, the whole sequence stops and `error` is raised. If every step completes, `done` is raised instead. Either flag stays high until the next `start`.

The PHY port uses a request/acknowledge handshake. The block raises `phy_req` and holds the address, direction and write data steady. The PHY answers with a single-cycle `phy_ack`, and on a read it drives `phy_rdata` in that same cycle.

Top module: `phy_init_seq`

## Requirements
- R1: After reset, `done`, `error` and `phy_req` are all low.
- R2: A `start` pulse while idle, done or in error begins a new sequence and clears `done` and `error` in the next cycle. A `start` that arrives while a sequence is running is ignored, and the access trace is the same as for an uninterrupted run.
- R3: `phy_req` stays high with `phy_addr`, `phy_we` and `phy_wdata` stable until `phy_ack` is seen. It drops in the cycle after the acknowledge. Each access is acknowledged exactly once.
- R4: A read-modify-write step reads an address (`phy_we`=0). It then writes back to that same address (`phy_we`=1) the byte it read, ORed with the step's mask.
- R5: The first two writes are to 0x01 with mask 0x42 (bit 6 retention enable, bit 1 power-down-bar enable), then to 0x02 with mask 0x02 (bit 1 trim enable).
- R6: After the pad steps, the block reads 0x03 repeatedly until bit 4 of the returned byte is 1. It never writes 0x03, and it makes no other access while polling.
- R7: If calibration has not reported done within CLK_MHZ*CAL_US cycles, counted from the start of polling, the block raises `error` and makes no further access.
- R8: After calibration, the line-enable writes follow in this order: 0x06|0x03, 0x08|0x02, 0x20|0x01, 0x07|0xFF, 0x09|0xFF, 0x21|0xFF, 0x22|0x01, 0x23|0x01.
- R9: Next comes 0x0F|0x07. The last access is a plain write of 0x04 to 0x11, with no read of 0x11. `done` then rises.
- R10: An access that receives no `phy_ack` within ACC_TIMEOUT cycles of its request ends the sequence with `error` high and `phy_req` low.
- R11: `done` and `error` are never both high. Each holds until the next accepted `start`. `phy_req` is low whenever either flag is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the power-up sequence |
| phy_req | output | 1 | PHY access request, held until acknowledged or timed out |
| phy_we | output | 1 | 1 for a write, 0 for a read |
| phy_addr | output | 8 | PHY register address |
| phy_wdata | output | 8 | Write data |
| phy_ack | input | 1 | Single-cycle acknowledge from the PHY |
| phy_rdata | input | 8 | Read data, valid while `phy_ack` is high on a read |
| done | output | 1 | Sequence finished successfully |
| error | output | 1 | Sequence aborted on a timeout |

## Verification
The assertions assume that the PHY raises `phy_ack` only while `phy_req` is high, for one cycle per request, and that `start` is a synchronous level sampled on the clock. The bench PHY model follows these rules. It answers after a programmable latency, acknowledges only a pending request, and never acknowledges again in the cycle where the request is withdrawn. When it is switched off it stays silent, which exercises the access timeout without breaking the handshake. The `start` stimulus is driven on the falling clock edge, so every pulse is seen at exactly one rising edge.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int PHY_AW = 8;
  localparam int PHY_DW = 8;

  // number of entries in the bring-up program and its index width
  localparam int STEP_COUNT = 13;
  localparam int STEP_IW    = $clog2(STEP_COUNT);

  // status bit that signals finished impedance calibration
  localparam int CAL_READY_BIT = 4;

  typedef enum logic [1:0] {
    OP_RMW  = 2'd0,   // read, OR mask in, write back
    OP_POLL = 2'd1,   // read until ready bit set
    OP_WR   = 2'd2    // plain write of mask value
  } step_op_e;

  typedef struct packed {
    step_op_e           op;
    logic [PHY_AW-1:0]  addr;
    logic [PHY_DW-1:0]  mask;
  } step_t;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_FETCH = 3'd1,
    SQ_RD    = 3'd2,
    SQ_RD_W  = 3'd3,
    SQ_WR    = 3'd4,
    SQ_WR_W  = 3'd5,
    SQ_DONE  = 3'd6,
    SQ_ERR   = 3'd7
  } seq_state_e;

endpackage

// File: rtl/phy_seq_steps.sv
module phy_seq_steps
  import phy_seq_pkg::*;
(
  input  logic [STEP_IW-1:0] idx,
  output step_t              step,
  output logic               is_last
);

  function automatic step_t mk(step_op_e op, logic [7:0] a, logic [7:0] m);
    step_t s;
    s.op   = op;
    s.addr = PHY_AW'(a);
    s.mask = PHY_DW'(m);
    return s;
  endfunction

  always_comb begin
    unique case (idx)
      STEP_IW'(0):  step = mk(OP_RMW,  8'h01, 8'h42);  // pad retention + power-down-bar
      STEP_IW'(1):  step = mk(OP_RMW,  8'h02, 8'h02);  // impedance trim enable
      STEP_IW'(2):  step = mk(OP_POLL, 8'h03, 8'h10);  // wait calibration
      STEP_IW'(3):  step = mk(OP_RMW,  8'h06, 8'h03);  // cmd + strobe receivers
      STEP_IW'(4):  step = mk(OP_RMW,  8'h08, 8'h02);  // cmd pull-up
      STEP_IW'(5):  step = mk(OP_RMW,  8'h20, 8'h01);  // cmd power
      STEP_IW'(6):  step = mk(OP_RMW,  8'h07, 8'hFF);  // data receivers
      STEP_IW'(7):  step = mk(OP_RMW,  8'h09, 8'hFF);  // data pull-ups
      STEP_IW'(8):  step = mk(OP_RMW,  8'h21, 8'hFF);  // data power
      STEP_IW'(9):  step = mk(OP_RMW,  8'h22, 8'h01);  // strobe power
      STEP_IW'(10): step = mk(OP_RMW,  8'h23, 8'h01);  // clock power
      STEP_IW'(11): step = mk(OP_RMW,  8'h0F, 8'h07);  // max clock buffer
      STEP_IW'(12): step = mk(OP_WR,   8'h11, 8'h04);  // legacy mode
      default:      step = mk(OP_WR,   8'h11, 8'h04);
    endcase
  end

  assign is_last = (idx == STEP_IW'(STEP_COUNT - 1));

endmodule

// File: rtl/phy_seq_access.sv
module phy_seq_access #(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int TIMEOUT = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ok,
  output logic          fail,
  output logic [DW-1:0] rdata,
  output logic          phy_req,
  output logic          phy_we,
  output logic [AW-1:0] phy_addr,
  output logic [DW-1:0] phy_wdata,
  input  logic          phy_ack,
  input  logic [DW-1:0] phy_rdata
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_req   <= 1'b0;
      phy_we    <= 1'b0;
      phy_addr  <= '0;
      phy_wdata <= '0;
      ok        <= 1'b0;
      fail      <= 1'b0;
      rdata     <= '0;
      wait_cnt  <= '0;
    end else begin
      ok   <= 1'b0;
      fail <= 1'b0;
      if (!phy_req) begin
        if (go) begin
          phy_req   <= 1'b1;
          phy_we    <= we;
          phy_addr  <= addr;
          phy_wdata <= wdata;
          wait_cnt  <= '0;
        end
      end else if (phy_ack) begin
        phy_req <= 1'b0;
        ok      <= 1'b1;
        if (!phy_we) rdata <= phy_rdata;
      end else if (wait_cnt == CNT_LAST) begin
        phy_req <= 1'b0;
        fail    <= 1'b1;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

  // R3: request fields hold while unacknowledged
  assert_req_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (phy_req && !phy_ack) |=> ($stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)));

  // R3: request withdrawn right after acknowledge
  assert_req_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (phy_req && phy_ack) |=> !phy_req);

  // R3: input rule - the PHY acknowledges only a pending request
  assert_ack_with_req_R3: assert property (@(posedge clk) disable iff (rst)
    phy_ack |-> phy_req);

  // R10: completion and timeout never reported together
  assert_ok_fail_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(ok && fail));

  // R10: a timeout follows a request left unanswered
  assert_fail_after_req_R10: assert property (@(posedge clk) disable iff (rst)
    fail |-> ($past(phy_req) && !$past(phy_ack)));

endmodule

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);

  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] TOP = TW'(LIMIT);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (en && !expired) begin
      cnt     <= cnt + 1'b1;
      expired <= (cnt == TOP - 1'b1);
    end
  end

  // R7: counter saturates at the limit
  assert_timer_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);

  // R7: expiry flag stays set until cleared
  assert_expiry_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (expired && !clr) |=> expired);

endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
  import phy_seq_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int CAL_US      = 100,
  parameter int ACC_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              phy_req,
  output logic              phy_we,
  output logic [PHY_AW-1:0] phy_addr,
  output logic [PHY_DW-1:0] phy_wdata,
  input  logic              phy_ack,
  input  logic [PHY_DW-1:0] phy_rdata,
  output logic              done,
  output logic              error
);

  localparam int CAL_CYCLES = CLK_MHZ * CAL_US;

  seq_state_e         state;
  logic [STEP_IW-1:0] idx;
  step_t              step;
  logic               is_last;

  logic               acc_go, acc_we, acc_ok, acc_fail;
  logic [PHY_DW-1:0]  acc_rdata, acc_wdata;
  logic               cal_clr, cal_en, cal_expired;
  logic               finished;

  phy_seq_steps u_steps (
    .idx     (idx),
    .step    (step),
    .is_last (is_last)
  );

  assign acc_go    = (state == SQ_RD) || (state == SQ_WR);
  assign acc_we    = (state == SQ_WR);
  assign acc_wdata = (step.op == OP_WR) ? step.mask : (acc_rdata | step.mask);

  phy_seq_access #(
    .AW      (PHY_AW),
    .DW      (PHY_DW),
    .TIMEOUT (ACC_TIMEOUT)
  ) u_access (
    .clk       (clk),
    .rst       (rst),
    .go        (acc_go),
    .we        (acc_we),
    .addr      (step.addr),
    .wdata     (acc_wdata),
    .ok        (acc_ok),
    .fail      (acc_fail),
    .rdata     (acc_rdata),
    .phy_req   (phy_req),
    .phy_we    (phy_we),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .phy_ack   (phy_ack),
    .phy_rdata (phy_rdata)
  );

  assign cal_clr = (state == SQ_FETCH);
  assign cal_en  = (step.op == OP_POLL) &&
                   ((state == SQ_RD) || (state == SQ_RD_W));

  phy_seq_timer #(
    .LIMIT (CAL_CYCLES)
  ) u_cal_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (cal_clr),
    .en      (cal_en),
    .expired (cal_expired)
  );

  assign finished = (state == SQ_IDLE) || (state == SQ_DONE) || (state == SQ_ERR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      idx   <= '0;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE, SQ_DONE, SQ_ERR: begin
          if (start) begin
            idx   <= '0;
            done  <= 1'b0;
            error <= 1'b0;
            state <= SQ_FETCH;
          end
        end
        SQ_FETCH: state <= (step.op == OP_WR) ? SQ_WR : SQ_RD;
        SQ_RD:    state <= SQ_RD_W;
        SQ_RD_W: begin
          if (acc_fail) begin
            state <= SQ_ERR;
            error <= 1'b1;
          end else if (acc_ok) begin
            if (step.op != OP_POLL) begin
              state <= SQ_WR;
            end else if (acc_rdata[CAL_READY_BIT]) begin
              idx   <= idx + 1'b1;
              state <= SQ_FETCH;
            end else if (cal_expired) begin
              state <= SQ_ERR;
              error <= 1'b1;
            end else begin
              state <= SQ_RD;
            end
          end
        end
        SQ_WR:    state <= SQ_WR_W;
        SQ_WR_W: begin
          if (acc_fail) begin
            state <= SQ_ERR;
            error <= 1'b1;
          end else if (acc_ok) begin
            if (is_last) begin
              state <= SQ_DONE;
              done  <= 1'b1;
            end else begin
              idx   <= idx + 1'b1;
              state <= SQ_FETCH;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R11: the two result flags never coincide
  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(done && error));

  // R11: done holds until a new start
  assert_done_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R11: error holds until a new start
  assert_error_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (error && !start) |=> error);

  // R11: no port activity once a result is reported
  assert_quiet_after_end_R11: assert property (@(posedge clk) disable iff (rst)
    phy_req |-> (!done && !error));

  // R2: start is ignored while busy
  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !finished) |=> !(done || error) || $past(state) == SQ_RD_W || $past(state) == SQ_WR_W);

  // R9: mode register only ever gets the legacy value
  assert_mode_value_R9: assert property (@(posedge clk) disable iff (rst)
    (phy_req && phy_we && phy_addr == PHY_AW'(8'h11)) |-> phy_wdata == PHY_DW'(8'h04));

  // R6: status register is never written
  assert_no_status_write_R6: assert property (@(posedge clk) disable iff (rst)
    (phy_req && phy_we) |-> phy_addr != PHY_AW'(8'h03));

endmodule

// File: tb/test_phy_init_seq.sv
module test_phy_init_seq;

  localparam int CLK_MHZ    = 50;
  localparam int CAL_US     = 100;
  localparam int ACC_TO     = 64;
  localparam int CAL_CYCLES = CLK_MHZ * CAL_US;
  localparam int LOG_N      = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       phy_req, phy_we, phy_ack, done, error;
  logic [7:0] phy_addr, phy_wdata, phy_rdata;

  int checks = 0;
  int fails  = 0;

  // model controls (driven only from the initial block)
  logic       m_en = 1'b1;
  int         m_lat = 1;
  int         m_cal_polls = 0;
  logic [7:0] m_pat = 8'h00;
  logic       m_clear = 1'b0;

  // model state (driven only from the model block)
  logic [7:0] mem [256];
  logic       wr_flag [256];
  logic [7:0] lg_addr [LOG_N];
  logic       lg_we   [LOG_N];
  logic [7:0] lg_data [LOG_N];
  int         lg_n, poll_n, lat_cnt;

  always #10 clk = ~clk;

  phy_init_seq #(
    .CLK_MHZ     (CLK_MHZ),
    .CAL_US      (CAL_US),
    .ACC_TIMEOUT (ACC_TO)
  ) i_phy_init_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .phy_req   (phy_req),
    .phy_we    (phy_we),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .phy_ack   (phy_ack),
    .phy_rdata (phy_rdata),
    .done      (done),
    .error     (error)
  );

  function automatic logic [7:0] seed(logic [7:0] a, logic [7:0] p);
    return (a * 8'd37) ^ p;
  endfunction

  // PHY register model with programmable latency
  always @(posedge clk) begin
    phy_ack <= 1'b0;
    if (rst || m_clear) begin
      lg_n    <= 0;
      poll_n  <= 0;
      lat_cnt <= 0;
      for (int i = 0; i < 256; i++) wr_flag[i] <= 1'b0;
    end else if (phy_req && !phy_ack && m_en) begin
      if (lat_cnt >= m_lat) begin
        lat_cnt <= 0;
        phy_ack <= 1'b1;
        if (lg_n < LOG_N) begin
          lg_addr[lg_n] <= phy_addr;
          lg_we[lg_n]   <= phy_we;
          lg_data[lg_n] <= phy_we ? phy_wdata : 8'h00;
        end
        lg_n <= lg_n + 1;
        if (phy_we) begin
          mem[phy_addr]     <= phy_wdata;
          wr_flag[phy_addr] <= 1'b1;
        end else if (phy_addr == 8'h03) begin
          phy_rdata <= (poll_n >= m_cal_polls) ? 8'h10 : 8'h00;
          poll_n    <= poll_n + 1;
        end else begin
          phy_rdata <= wr_flag[phy_addr] ? mem[phy_addr] : seed(phy_addr, m_pat);
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  // expected write program
  function automatic logic [7:0] exp_addr(int i);
    case (i)
      0: return 8'h01;  1: return 8'h02;  2: return 8'h06;  3: return 8'h08;
      4: return 8'h20;  5: return 8'h07;  6: return 8'h09;  7: return 8'h21;
      8: return 8'h22;  9: return 8'h23;  10: return 8'h0F; default: return 8'h11;
    endcase
  endfunction

  function automatic logic [7:0] exp_mask(int i);
    case (i)
      0: return 8'h42;  1: return 8'h02;  2: return 8'h03;  3: return 8'h02;
      4: return 8'h01;  5: return 8'hFF;  6: return 8'hFF;  7: return 8'hFF;
      8: return 8'h01;  9: return 8'h01;  10: return 8'h07; default: return 8'h04;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    @(negedge clk); m_clear = 1'b1;
    @(negedge clk); m_clear = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end(input int max, output int cyc);
    cyc = 1;
    while (!(done || error) && cyc < max) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // check the whole trace of a successful run
  task automatic check_trace(input string tag);
    int w;
    int polls;
    int exp_n;
    w = 0;
    polls = 0;
    exp_n = 23 + m_cal_polls + 1;
    chk(lg_n == exp_n, {tag, " R3 access count"}, lg_n, exp_n);
    for (int k = 0; k < lg_n && k < LOG_N; k++) begin
      if (lg_we[k]) begin
        logic [7:0] e;
        e = (w == 11) ? exp_mask(w) : (seed(exp_addr(w), m_pat) | exp_mask(w));
        chk(lg_addr[k] == exp_addr(w),
            (w < 2) ? {tag, " R5 write addr"} : (w < 10) ? {tag, " R8 write addr"} : {tag, " R9 write addr"},
            lg_addr[k], exp_addr(w));
        chk(lg_data[k] == e, {tag, " R4 write data"}, lg_data[k], e);
        if (w < 11)
          chk(!lg_we[k-1] && lg_addr[k-1] == lg_addr[k], {tag, " R4 read before write"},
              lg_addr[k-1], lg_addr[k]);
        else
          chk(lg_we[k-1] && lg_addr[k-1] == 8'h0F, {tag, " R9 no read of mode reg"},
              lg_addr[k-1], 8'h0F);
        w++;
      end else if (lg_addr[k] == 8'h03) begin
        polls++;
        chk(w == 2, {tag, " R6 poll position"}, w, 2);
      end
    end
    chk(w == 12, {tag, " R8 write count"}, w, 12);
    chk(polls == m_cal_polls + 1, {tag, " R6 poll count"}, polls, m_cal_polls + 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(error == 1'b0, "R1 error after reset", error, 0);
    chk(phy_req == 1'b0, "R1 req after reset", phy_req, 0);
  endtask

  task automatic t_normal(input logic [7:0] pat, input int lat, input int polls, input string tag);
    int cyc;
    m_pat = pat; m_lat = lat; m_cal_polls = polls; m_en = 1'b1;
    clear_model();
    pulse_start();
    wait_end(20000, cyc);
    chk(done == 1'b1, {tag, " R9 done"}, done, 1);
    chk(error == 1'b0, {tag, " R11 no error"}, error, 0);
    check_trace(tag);
  endtask

  task automatic t_busy_start();
    int cyc;
    m_pat = 8'h3C; m_lat = 3; m_cal_polls = 2; m_en = 1'b1;
    clear_model();
    pulse_start();
    repeat (25) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end(20000, cyc);
    chk(done == 1'b1, "R2 done despite busy start", done, 1);
    check_trace("busy");
  endtask

  task automatic t_hold_and_restart();
    repeat (30) @(negedge clk);
    chk(done == 1'b1 && error == 1'b0, "R11 done held", done, 1);
    chk(phy_req == 1'b0, "R11 quiet while done", phy_req, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R2 start clears done", done, 0);
    begin
      int cyc;
      wait_end(20000, cyc);
    end
    chk(done == 1'b1, "R2 restart completes", done, 1);
  endtask

  task automatic t_cal_timeout();
    int cyc;
    int n0;
    m_pat = 8'h00; m_lat = 1; m_cal_polls = 1000000; m_en = 1'b1;
    clear_model();
    pulse_start();
    wait_end(CAL_CYCLES + 2000, cyc);
    chk(error == 1'b1, "R7 cal timeout error", error, 1);
    chk(done == 1'b0, "R11 no done on timeout", done, 0);
    chk(cyc >= CAL_CYCLES && cyc <= CAL_CYCLES + 100, "R7 timeout window", cyc, CAL_CYCLES);
    n0 = lg_n;
    repeat (40) @(negedge clk);
    chk(lg_n == n0 && !phy_req, "R7 no access after error", lg_n, n0);
    chk(error == 1'b1, "R11 error held", error, 1);
    begin
      int wcount;
      wcount = 0;
      for (int k = 0; k < LOG_N && k < lg_n; k++) if (lg_we[k]) wcount++;
      chk(wcount == 2, "R6 only pad writes before timeout", wcount, 2);
    end
  endtask

  task automatic t_access_timeout();
    int cyc;
    m_en = 1'b0; m_lat = 1; m_cal_polls = 0;
    clear_model();
    pulse_start();
    @(negedge clk);
    chk(error == 1'b0, "R2 start clears error", error, 0);
    wait_end(ACC_TO + 200, cyc);
    chk(error == 1'b1, "R10 access timeout error", error, 1);
    chk(cyc >= ACC_TO && cyc <= ACC_TO + 10, "R10 timeout window", cyc, ACC_TO);
    chk(phy_req == 1'b0, "R10 req dropped", phy_req, 0);
    m_en = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_normal(8'h00, 1, 0, "zero");
    t_normal(8'hA5, 2, 5, "pat");
    t_normal(8'h5A, 0, 1, "fast");
    t_busy_start();
    t_hold_and_restart();
    t_cal_timeout();
    t_access_timeout();
    t_normal(8'h81, 1, 3, "recover");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule